// File: doc/BRIEF.md
# Fault Detection Latency Monitor

This block times how quickly a circuit under test reacts to a fault injected into it. A start strobe marks the cycle in which a fault is applied and carries that fault's index. From that cycle on, the block counts clock cycles until the circuit drives a non-idle code on its error-code pins, or until a programmable observation window runs out. The outcome of each experiment is one 16-bit record: either the measured latency in cycles or an all-ones sentinel meaning "never detected". The record is written to a 64-entry result memory, in the slot given by the fault index.

A host reads results through a combinational read port. Each slot has a valid flag that is set when the slot is written and cleared, for all slots at once, by a clear input. A busy output and a one-cycle done pulse frame each experiment. A start that arrives while an experiment is already running is dropped and sets a sticky overrun flag.

The control is a three-state machine. `ST_IDLE` waits for a start. `ST_MEASURE` counts the elapsed cycles. `ST_WRITE` commits the record. The transitions are:
- idle-to-measure: a start with no error code, on a window wider than one cycle.
- idle-to-write: a start that arrives together with an error code, or on a one-cycle window.
- measure-to-write: an error code is seen, or the last cycle of the window passes.
- write-to-idle: always, after one cycle.

Top module: `fault_latency_monitor`

## Requirements
- R1: `window_i` is captured at the accepted start. If the error code (idle code 0) first differs from 0 in the cycle L clock cycles after the start cycle, and 0 < L < window, L is stored as the result.
- R2: An error code that differs from 0 in the same cycle as the accepted start gives a result of 0.
- R3: If no non-idle error code appears within the window (latencies 0 to window-1), the result is 16'hFFFF.
- R4: A window value of 0 behaves exactly like a window of 1.
- R5: Each result is written to slot `fault_idx_i` (captured at the start) of a 64-entry memory. Reading that slot returns the result with `rd_valid_o`=1. An unwritten slot reads `rd_data_o`=0 with `rd_valid_o`=0.
- R6: `clear_i` clears the valid flag of every slot. A write in the same cycle as a clear still leaves its own slot valid.
- R7: `busy_o` is high from the cycle after the start edge until the record has been written. `done_o` is high for exactly one cycle, the cycle whose closing edge writes the record.
- R8: A start while `busy_o` is high is ignored: it does not change the running measurement and writes no slot. It sets `overrun_o`, which stays set until reset.
- R9: After reset, `busy_o`, `done_o` and `overrun_o` are 0 and all slots read invalid.
- R10: Any non-zero error code counts as detection, whatever its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Fault-injected strobe |
| fault_idx_i | input | 6 | Index of the injected fault |
| window_i | input | 16 | Observation window in cycles (0 means 1) |
| err_code_i | input | 4 | Error code from the circuit under test, 0 = idle |
| clear_i | input | 1 | Clears all valid flags |
| rd_addr_i | input | 6 | Result read address |
| rd_data_o | output | 16 | Result at rd_addr_i (0 if invalid) |
| rd_valid_o | output | 1 | Valid flag of that slot |
| busy_o | output | 1 | Experiment in progress |
| done_o | output | 1 | One-cycle pulse with the result write |
| overrun_o | output | 1 | Sticky: start arrived while busy |

## Verification
Two pairs of functions can fall into the same cycle.

The first pair is the start strobe and the detection. The bench raises the error code together with the start, and checks that 0 is recorded rather than 1.

The second pair is a host clear and a result write. The bench asserts `clear_i` in the exact `ST_WRITE` cycle. It expects the slot being written to stay valid with its value, while a slot written earlier reads back invalid. A third overlap is a start that lands during a measurement. It must leave the running result and the slot named by the stray index untouched, and raise the overrun flag.

// File: rtl/flm_pkg.sv
package flm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_MEASURE = 2'd1,
        ST_WRITE   = 2'd2
    } flm_state_e;

endpackage

// File: rtl/flm_window_cnt.sv
module flm_window_cnt #(
    parameter int LAT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             inc_i,
    input  logic [LAT_W-1:0] win_i,
    output logic [LAT_W-1:0] elapsed_o,
    output logic             last_now_o
);

    localparam logic [LAT_W-1:0] ONE = LAT_W'(1);

    logic [LAT_W-1:0] elapsed_q;
    logic [LAT_W-1:0] win_q;
    logic [LAT_W-1:0] win_eff;

    // a zero window is promoted to one cycle
    always_comb begin
        win_eff = (win_i == '0) ? ONE : win_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed_q <= '0;
            win_q     <= ONE;
        end else if (load_i) begin
            elapsed_q <= ONE;
            win_q     <= win_eff;
        end else if (inc_i) begin
            elapsed_q <= elapsed_q + ONE;
        end
    end

    // last cycle of the window: at the start itself the fresh window is used
    always_comb begin
        if (load_i) begin
            last_now_o = (win_eff == ONE);
        end else begin
            last_now_o = (elapsed_q == (win_q - ONE));
        end
        elapsed_o = elapsed_q;
    end

endmodule

// File: rtl/flm_ctrl.sv
module flm_ctrl
    import flm_pkg::*;
#(
    parameter int              IDX_W     = 6,
    parameter int              LAT_W     = 16,
    parameter int              ERR_W     = 4,
    parameter logic [ERR_W-1:0] IDLE_CODE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [ERR_W-1:0] err_code_i,
    input  logic             last_now_i,
    input  logic [LAT_W-1:0] elapsed_i,
    output logic             load_o,
    output logic             inc_o,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic [LAT_W-1:0] wr_data_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             overrun_o
);

    localparam logic [LAT_W-1:0] NEVER = '1;

    flm_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [LAT_W-1:0] res_q;
    logic             ovr_q;
    logic             hit;
    logic             accept;

    always_comb begin
        hit    = (err_code_i != IDLE_CODE);
        accept = start_i && (state_q == ST_IDLE);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = (hit || last_now_i) ? ST_WRITE : ST_MEASURE;
                end
            end
            ST_MEASURE: begin
                if (hit || last_now_i) begin
                    state_d = ST_WRITE;
                end
            end
            ST_WRITE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // captured index, result and sticky overrun
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            res_q <= '0;
            ovr_q <= 1'b0;
        end else begin
            if (accept) begin
                idx_q <= idx_i;
            end
            if (start_i && (state_q != ST_IDLE)) begin
                ovr_q <= 1'b1;
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (hit) begin
                            res_q <= '0;
                        end else if (last_now_i) begin
                            res_q <= NEVER;
                        end
                    end
                end
                ST_MEASURE: begin
                    if (hit) begin
                        res_q <= elapsed_i;
                    end else if (last_now_i) begin
                        res_q <= NEVER;
                    end
                end
                ST_WRITE: begin
                    res_q <= res_q;
                end
                default: begin
                    res_q <= res_q;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        load_o    = accept;
        inc_o     = (state_q == ST_MEASURE) && !hit && !last_now_i;
        wr_en_o   = (state_q == ST_WRITE);
        done_o    = (state_q == ST_WRITE);
        busy_o    = (state_q != ST_IDLE);
        wr_idx_o  = idx_q;
        wr_data_o = res_q;
        overrun_o = ovr_q;
    end

    AST_LATENCY_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEASURE && hit) |=> (done_o && wr_data_o == $past(elapsed_i))); // R1
    AST_SAME_CYCLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && hit) |=> (done_o && wr_data_o == '0)); // R2
    AST_TIMEOUT_SENTINEL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEASURE && !hit && last_now_i) |=> (wr_data_o == NEVER)); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R7
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o); // R8
    AST_IGNORED_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |=> (overrun_o && $stable(wr_idx_o))); // R8

endmodule

// File: rtl/flm_result_mem.sv
module flm_result_mem #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              clear_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DEPTH-1:0]  vld_q;
    logic [DEPTH-1:0]  vld_d;

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem_q[wr_addr_i] <= wr_data_i;
        end
    end

    // clear first, then the write of this cycle re-validates its slot
    always_comb begin
        vld_d = clear_i ? '0 : vld_q;
        if (wr_en_i) begin
            vld_d[wr_addr_i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q <= vld_d;
        end
    end

    always_comb begin
        rd_valid_o = vld_q[rd_addr_i];
        rd_data_o  = vld_q[rd_addr_i] ? mem_q[rd_addr_i] : '0;
    end

    AST_WRITE_VALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> vld_q[$past(wr_addr_i)]); // R5
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !wr_en_i) |=> (vld_q == '0)); // R6
    AST_CLEAR_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && wr_en_i) |=> ($countones(vld_q) == 1)); // R6

endmodule

// File: rtl/fault_latency_monitor.sv
module fault_latency_monitor #(
    parameter int               IDX_W     = 6,
    parameter int               LAT_W     = 16,
    parameter int               ERR_W     = 4,
    parameter logic [ERR_W-1:0] IDLE_CODE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [IDX_W-1:0] fault_idx_i,
    input  logic [LAT_W-1:0] window_i,
    input  logic [ERR_W-1:0] err_code_i,
    input  logic             clear_i,
    input  logic [IDX_W-1:0] rd_addr_i,
    output logic [LAT_W-1:0] rd_data_o,
    output logic             rd_valid_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             overrun_o
);

    logic             load;
    logic             inc;
    logic             last_now;
    logic [LAT_W-1:0] elapsed;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [LAT_W-1:0] wr_data;

    flm_window_cnt #(
        .LAT_W (LAT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .inc_i      (inc),
        .win_i      (window_i),
        .elapsed_o  (elapsed),
        .last_now_o (last_now)
    );

    flm_ctrl #(
        .IDX_W     (IDX_W),
        .LAT_W     (LAT_W),
        .ERR_W     (ERR_W),
        .IDLE_CODE (IDLE_CODE)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .idx_i      (fault_idx_i),
        .err_code_i (err_code_i),
        .last_now_i (last_now),
        .elapsed_i  (elapsed),
        .load_o     (load),
        .inc_o      (inc),
        .wr_en_o    (wr_en),
        .wr_idx_o   (wr_idx),
        .wr_data_o  (wr_data),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .overrun_o  (overrun_o)
    );

    flm_result_mem #(
        .ADDR_W (IDX_W),
        .DATA_W (LAT_W)
    ) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_idx),
        .wr_data_i  (wr_data),
        .clear_i    (clear_i),
        .rd_addr_i  (rd_addr_i),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o)
    );

endmodule

// File: tb/tb_fault_latency_monitor.sv
module tb_fault_latency_monitor;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [5:0]  fault_idx_i = '0;
    logic [15:0] window_i = '0;
    logic [3:0]  err_code_i = '0;
    logic        clear_i = 1'b0;
    logic [5:0]  rd_addr_i = '0;
    logic [15:0] rd_data_o;
    logic        rd_valid_o;
    logic        busy_o;
    logic        done_o;
    logic        overrun_o;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;
    logic [21:0] exp_q [$];

    fault_latency_monitor dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .fault_idx_i (fault_idx_i),
        .window_i    (window_i),
        .err_code_i  (err_code_i),
        .clear_i     (clear_i),
        .rd_addr_i   (rd_addr_i),
        .rd_data_o   (rd_data_o),
        .rd_valid_o  (rd_valid_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .overrun_o   (overrun_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // driver: one experiment; lat<0 means no detection, ovr_c/clr_c = cycle for stray start / clear
    task automatic run(input logic [5:0] idx, input logic [15:0] win, input int lat,
                       input logic [3:0] code, input int ovr_c, input int clr_c);
        int weff;
        logic [15:0] exp_v;
        weff  = (win == 0) ? 1 : int'(win);
        exp_v = (lat >= 0 && lat < weff) ? 16'(lat) : 16'hFFFF;
        exp_q.push_back({idx, exp_v});
        @(negedge clk);
        start_i     = 1'b1;
        fault_idx_i = idx;
        window_i    = win;
        err_code_i  = (lat == 0) ? code : 4'h0;
        for (int c = 1; c < 70000; c++) begin
            @(negedge clk);
            start_i = (c == ovr_c);
            if (c == ovr_c) fault_idx_i = 6'd8;
            clear_i = (c == clr_c);
            if (c == lat) err_code_i = code;
            if (!busy_o && !start_i) break;
        end
        err_code_i = 4'h0;
        clear_i    = 1'b0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            logic [21:0] e;
            check("R7 busy during done", busy_o, 1'b1);
            if (exp_q.size() == 0) begin
                check("R7 unexpected done", 1'b1, 1'b0);
            end else begin
                e = exp_q.pop_front();
                rd_addr_i = e[21:16];
                @(negedge clk);
                check("R7 done one cycle", done_o, 1'b0);
                check("R7 busy released", busy_o, 1'b0);
                check($sformatf("R5 valid slot %0d", e[21:16]), rd_valid_o, 1'b1);
                check($sformatf("R1/R2/R3 result slot %0d", e[21:16]), rd_data_o, e[15:0]);
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 busy reset", busy_o, 1'b0);
        check("R9 done reset", done_o, 1'b0);
        check("R9 overrun reset", overrun_o, 1'b0);
        check("R9 slot invalid", rd_valid_o, 1'b0);
        check("R5 invalid reads zero", rd_data_o, 16'h0);

        run(6'd0, 16'd10, 3, 4'h1, -1, -1);          // R1
        run(6'd1, 16'd10, 0, 4'h1, -1, -1);          // R2
        run(6'd2, 16'd10, 9, 4'h2, -1, -1);          // R1 last in window
        run(6'd3, 16'd10, 10, 4'h2, -1, -1);         // R3 one past window
        run(6'd4, 16'd10, -1, 4'h1, -1, -1);         // R3 never
        run(6'd5, 16'd0, 0, 4'h1, -1, -1);           // R4
        run(6'd6, 16'd0, 1, 4'h1, -1, -1);           // R4 -> sentinel
        run(6'd9, 16'd1, 0, 4'hF, -1, -1);           // R10 code F
        run(6'd63, 16'd300, 200, 4'h8, -1, -1);      // R10 code 8, top slot
        check("R8 no overrun yet", overrun_o, 1'b0);
        run(6'd7, 16'd20, 5, 4'h1, 2, -1);           // R8 stray start
        repeat (2) @(negedge clk);
        check("R8 overrun set", overrun_o, 1'b1);
        rd_addr_i = 6'd8;
        @(negedge clk);
        check("R8 stray slot unwritten", rd_valid_o, 1'b0);
        rd_addr_i = 6'd3;
        @(negedge clk);
        check("R3 slot 3 kept", rd_data_o, 16'hFFFF);

        run(6'd10, 16'd5, 0, 4'h1, -1, 1);           // R6 clear with write
        repeat (2) @(negedge clk);
        rd_addr_i = 6'd0;
        @(negedge clk);
        check("R6 slot 0 cleared", rd_valid_o, 1'b0);
        check("R6 cleared reads zero", rd_data_o, 16'h0);
        rd_addr_i = 6'd10;
        @(negedge clk);
        check("R6 written slot survives", rd_valid_o, 1'b1);
        check("R8 overrun still set", overrun_o, 1'b1);
        check("R7 queue drained", exp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule